// File: doc/BRIEF.md
# Double-Trap Guard

This block keeps the machine-level double-trap bit and the two supervisor-level double-trap bits (the one in the supervisor status register and the one in the virtual-supervisor status register). It decides, for every trap request, whether the trap can be delivered or whether it reached a handler that was not yet ready for it. A trap that is not ready for delivery is called an unexpected trap. Each trap request is tagged as an ordinary trap or as a resumable non-maskable interrupt (RNMI). The request carries the current privilege mode, the target privilege mode and the NMI-enable bit. Return events (MRET, SRET, MNRET) carry the privilege mode being returned to, and they clear the bits under rules that depend on that mode.

All outputs are registered. A trap or return presented in one clock cycle is seen on the bit outputs and on the trap-taken or unexpected-trap pulse after the next rising edge. Reset is synchronous and active high.

Top module: `dbltrap_guard`

## Requirements
- R1: After reset, the machine double-trap bit reads 1 and both supervisor double-trap bits read 0. Trap-taken and unexpected-trap read 0.
- R2: An ordinary trap whose target is M (code 3) is delivered when the machine double-trap bit is 0 and the R5 condition does not hold. Trap-taken pulses and the machine double-trap bit becomes 1.
- R3: An ordinary trap targeting M while the machine double-trap bit is 1 raises the unexpected-trap pulse instead of trap-taken. No double-trap bit changes.
- R4: An RNMI trap is never classified as unexpected because of the machine double-trap bit, and it never changes any double-trap bit. Outside the R5 condition it produces trap-taken.
- R5: Any trap, ordinary or RNMI, requested while the current mode is M with NMI-enable at 0 is unexpected. No bit changes.
- R6: A delivered ordinary trap targeting S (code 1) sets the supervisor bit. One targeting VS (code 5) sets the virtual-supervisor bit. Trap-taken pulses in both cases.
- R7: Return kinds are coded MRET=0, SRET=1, MNRET=2; code 3 has no effect. MRET or SRET executed with current mode M clears the machine bit. The supervisor bit is also cleared when the new mode is U (0), VS (5) or VU (4). The virtual-supervisor bit is also cleared when the new mode is VU.
- R8: MRET or SRET executed with a current mode other than M changes no bit.
- R9: MNRET clears the machine bit only when the new mode is not M. It clears the supervisor bits under the same U, VS and VU rules as R7.
- R10: When a trap request and a return event arrive in the same cycle, the trap is acted on and the return is ignored.
- R11: Trap-taken and unexpected-trap are single-cycle pulses, one cycle after the request, and never high together. In a cycle with no event, all bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request this cycle |
| trap_is_rnmi | input | 1 | Request is a resumable NMI |
| trap_tgt_priv | input | 3 | Target privilege mode of the trap |
| cur_priv | input | 3 | Current privilege mode |
| nmi_en | input | 1 | NMI-enable bit |
| ret_valid | input | 1 | Return instruction executed this cycle |
| ret_kind | input | 2 | 0 MRET, 1 SRET, 2 MNRET, 3 none |
| ret_new_priv | input | 3 | Privilege mode being returned to |
| mdt_o | output | 1 | Machine double-trap bit |
| sdt_o | output | 1 | Supervisor double-trap bit |
| vsdt_o | output | 1 | Virtual-supervisor double-trap bit |
| trap_taken_o | output | 1 | Pulse: trap delivered normally |
| unexp_trap_o | output | 1 | Pulse: unexpected trap |

## Verification
Each result of this block is due exactly one rising edge after its stimulus. The three bits take their new value on that edge, and both pulses are high only in the cycle that follows it. The bench drives each vector on a falling edge and waits for one rising edge. It then compares every output on the next falling edge. A further idle step confirms that the pulses have dropped and the bits have held. The state carries from vector to vector, so the expected bits in the table are worked out along the sequence.

// File: rtl/dbltrap_pkg.sv
package dbltrap_pkg;
  localparam int PRIV_W = 3;
  localparam int KIND_W = 2;
  localparam int NFLAG  = 3;   // machine, supervisor, virtual-supervisor

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U  = 3'd0,
    PRIV_S  = 3'd1,
    PRIV_M  = 3'd3,
    PRIV_VU = 3'd4,
    PRIV_VS = 3'd5
  } priv_e;

  typedef enum logic [KIND_W-1:0] {
    RK_MRET  = 2'd0,
    RK_SRET  = 2'd1,
    RK_MNRET = 2'd2,
    RK_NONE  = 2'd3
  } ret_kind_e;

  localparam int F_M  = 0;
  localparam int F_S  = 1;
  localparam int F_VS = 2;
endpackage

// File: rtl/dbltrap_classify.sv
module dbltrap_classify
  import dbltrap_pkg::*;
(
  input  logic              trap_req,
  input  logic              is_rnmi,
  input  logic [PRIV_W-1:0] tgt,
  input  logic [PRIV_W-1:0] cur,
  input  logic              nmi_en,
  input  logic              mdt,
  output logic              unexp,
  output logic              take,
  output logic [NFLAG-1:0]  set_f
);
  logic masked_m;
  logic reentry;

  always_comb begin
    // in M with NMI-enable low, any trap is unexpected
    masked_m = (cur == PRIV_M) && !nmi_en;
    // ordinary trap into M while the handler is still busy
    reentry  = !is_rnmi && (tgt == PRIV_M) && mdt;
    unexp    = trap_req && (masked_m || reentry);
    take     = trap_req && !unexp;
    set_f        = '0;
    set_f[F_M]   = take && !is_rnmi && (tgt == PRIV_M);
    set_f[F_S]   = take && !is_rnmi && (tgt == PRIV_S);
    set_f[F_VS]  = take && !is_rnmi && (tgt == PRIV_VS);
  end
endmodule

// File: rtl/dbltrap_retclr.sv
module dbltrap_retclr
  import dbltrap_pkg::*;
(
  input  logic              ret_valid,
  input  logic [KIND_W-1:0] kind,
  input  logic [PRIV_W-1:0] cur,
  input  logic [PRIV_W-1:0] new_priv,
  output logic [NFLAG-1:0]  clr_f
);
  logic applies;
  logic clr_mach;
  logic to_lower;

  always_comb begin
    applies  = 1'b0;
    clr_mach = 1'b0;
    unique case (kind)
      RK_MRET, RK_SRET: begin
        applies  = ret_valid && (cur == PRIV_M);
        clr_mach = applies;
      end
      RK_MNRET: begin
        applies  = ret_valid;
        clr_mach = applies && (new_priv != PRIV_M);
      end
      default: begin
        applies  = 1'b0;
        clr_mach = 1'b0;
      end
    endcase
    to_lower = (new_priv == PRIV_U) || (new_priv == PRIV_VS) ||
               (new_priv == PRIV_VU);
    clr_f        = '0;
    clr_f[F_M]   = clr_mach;
    clr_f[F_S]   = applies && to_lower;
    clr_f[F_VS]  = applies && (new_priv == PRIV_VU);
  end
endmodule

// File: rtl/dbltrap_flag.sv
module dbltrap_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/dbltrap_guard.sv
module dbltrap_guard
  import dbltrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic              trap_is_rnmi,
  input  logic [PRIV_W-1:0] trap_tgt_priv,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              nmi_en,
  input  logic              ret_valid,
  input  logic [KIND_W-1:0] ret_kind,
  input  logic [PRIV_W-1:0] ret_new_priv,
  output logic              mdt_o,
  output logic              sdt_o,
  output logic              vsdt_o,
  output logic              trap_taken_o,
  output logic              unexp_trap_o
);
  localparam logic [NFLAG-1:0] FLAG_RST = 3'b001;  // machine bit resets high

  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] set_f;
  logic [NFLAG-1:0] clr_raw;
  logic [NFLAG-1:0] clr_f;
  logic             unexp_c;
  logic             take_c;

  dbltrap_classify u_cls (
    .trap_req (trap_req),
    .is_rnmi  (trap_is_rnmi),
    .tgt      (trap_tgt_priv),
    .cur      (cur_priv),
    .nmi_en   (nmi_en),
    .mdt      (flags_q[F_M]),
    .unexp    (unexp_c),
    .take     (take_c),
    .set_f    (set_f)
  );

  dbltrap_retclr u_ret (
    .ret_valid (ret_valid),
    .kind      (ret_kind),
    .cur       (cur_priv),
    .new_priv  (ret_new_priv),
    .clr_f     (clr_raw)
  );

  // a trap in the same cycle wins over any return
  assign clr_f = trap_req ? '0 : clr_raw;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    dbltrap_flag #(.RST_VAL(FLAG_RST[g])) u_flag (
      .clk (clk),
      .rst (rst),
      .set (set_f[g]),
      .clr (clr_f[g]),
      .q   (flags_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_taken_o <= 1'b0;
      unexp_trap_o <= 1'b0;
    end else begin
      trap_taken_o <= take_c;
      unexp_trap_o <= unexp_c;
    end
  end

  assign mdt_o  = flags_q[F_M];
  assign sdt_o  = flags_q[F_S];
  assign vsdt_o = flags_q[F_VS];

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(trap_taken_o && unexp_trap_o));

  // R2
  mdt_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !trap_is_rnmi && trap_tgt_priv == PRIV_M && !unexp_trap_o
     && !mdt_o && !(cur_priv == PRIV_M && !nmi_en)) |=> (mdt_o && trap_taken_o));

  // R3
  reentry_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !trap_is_rnmi && trap_tgt_priv == PRIV_M && mdt_o)
      |=> (unexp_trap_o && !trap_taken_o && mdt_o));

  // R4
  rnmi_keeps_mdt_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_is_rnmi) |=> $stable(mdt_o));

  // R5
  masked_m_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && cur_priv == PRIV_M && !nmi_en) |=> unexp_trap_o);

  // R10
  trap_beats_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && ret_valid && mdt_o) |=> mdt_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && !ret_valid) |=> ($stable({mdt_o, sdt_o, vsdt_o})
      && !trap_taken_o && !unexp_trap_o));
endmodule

// File: tb/dbltrap_guard_tb_top.sv
`timescale 1ns/1ps
module dbltrap_guard_tb_top;
  localparam logic [2:0] U = 3'd0, S = 3'd1, M = 3'd3, VU = 3'd4, VS = 3'd5;
  localparam logic [1:0] KM = 2'd0, KS = 2'd1, KN = 2'd2, KX = 2'd3;

  typedef struct packed {
    logic       trq;
    logic       rnmi;
    logic [2:0] tgt;
    logic [2:0] cur;
    logic       nmie;
    logic       rv;
    logic [1:0] rk;
    logic [2:0] rnew;
    logic       emdt;
    logic       esdt;
    logic       evsdt;
    logic       etak;
    logic       eunx;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  // trq rnmi tgt cur nmie rv rk rnew | mdt sdt vsdt tak unx | req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KM,U ,1'b0,1'b0,1'b0,1'b0,1'b0,4'd7 },  // R7 MRET to U
    '{1'b1,1'b0,S ,U ,1'b1,1'b0,KM,U ,1'b0,1'b1,1'b0,1'b1,1'b0,4'd6 },  // R6 trap to S
    '{1'b1,1'b0,VS,VU,1'b1,1'b0,KM,U ,1'b0,1'b1,1'b1,1'b1,1'b0,4'd6 },  // R6 trap to VS
    '{1'b1,1'b0,M ,S ,1'b1,1'b0,KM,U ,1'b1,1'b1,1'b1,1'b1,1'b0,4'd2 },  // R2 trap to M
    '{1'b1,1'b0,M ,M ,1'b1,1'b0,KM,U ,1'b1,1'b1,1'b1,1'b0,1'b1,4'd3 },  // R3 reentry
    '{1'b1,1'b1,M ,M ,1'b1,1'b0,KM,U ,1'b1,1'b1,1'b1,1'b1,1'b0,4'd4 },  // R4 RNMI mdt=1
    '{1'b0,1'b0,U ,S ,1'b1,1'b1,KS,U ,1'b1,1'b1,1'b1,1'b0,1'b0,4'd8 },  // R8 SRET from S
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KN,M ,1'b1,1'b1,1'b1,1'b0,1'b0,4'd9 },  // R9 MNRET to M
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KN,S ,1'b0,1'b1,1'b1,1'b0,1'b0,4'd9 },  // R9 MNRET to S
    '{1'b1,1'b1,M ,S ,1'b1,1'b0,KM,U ,1'b0,1'b1,1'b1,1'b1,1'b0,4'd4 },  // R4 RNMI mdt=0
    '{1'b1,1'b0,M ,M ,1'b0,1'b0,KM,U ,1'b0,1'b1,1'b1,1'b0,1'b1,4'd5 },  // R5 ordinary
    '{1'b1,1'b1,M ,M ,1'b0,1'b0,KM,U ,1'b0,1'b1,1'b1,1'b0,1'b1,4'd5 },  // R5 RNMI
    '{1'b1,1'b0,M ,U ,1'b1,1'b1,KN,U ,1'b1,1'b1,1'b1,1'b1,1'b0,4'd10},  // R10 trap+ret
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KS,VS,1'b0,1'b0,1'b1,1'b0,1'b0,4'd7 },  // R7 SRET to VS
    '{1'b1,1'b0,S ,U ,1'b1,1'b0,KM,U ,1'b0,1'b1,1'b1,1'b1,1'b0,4'd6 },  // R6 trap to S
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KM,VU,1'b0,1'b0,1'b0,1'b0,1'b0,4'd7 },  // R7 MRET to VU
    '{1'b1,1'b0,VS,VU,1'b1,1'b0,KM,U ,1'b0,1'b0,1'b1,1'b1,1'b0,4'd6 },  // R6 trap to VS
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KN,VU,1'b0,1'b0,1'b0,1'b0,1'b0,4'd9 },  // R9 MNRET to VU
    '{1'b0,1'b0,U ,U ,1'b1,1'b0,KM,U ,1'b0,1'b0,1'b0,1'b0,1'b0,4'd11},  // R11 idle
    '{1'b1,1'b0,M ,U ,1'b1,1'b0,KM,U ,1'b1,1'b0,1'b0,1'b1,1'b0,4'd2 },  // R2 trap to M
    '{1'b0,1'b0,U ,M ,1'b1,1'b1,KX,U ,1'b1,1'b0,1'b0,1'b0,1'b0,4'd7 }   // R7 kind 3 no-op
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       trap_req, trap_is_rnmi, nmi_en, ret_valid;
  logic [2:0] trap_tgt_priv, cur_priv, ret_new_priv;
  logic [1:0] ret_kind;
  logic       mdt_o, sdt_o, vsdt_o, trap_taken_o, unexp_trap_o;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  dbltrap_guard dut_i (
    .clk           (clk),
    .rst           (rst),
    .trap_req      (trap_req),
    .trap_is_rnmi  (trap_is_rnmi),
    .trap_tgt_priv (trap_tgt_priv),
    .cur_priv      (cur_priv),
    .nmi_en        (nmi_en),
    .ret_valid     (ret_valid),
    .ret_kind      (ret_kind),
    .ret_new_priv  (ret_new_priv),
    .mdt_o         (mdt_o),
    .sdt_o         (sdt_o),
    .vsdt_o        (vsdt_o),
    .trap_taken_o  (trap_taken_o),
    .unexp_trap_o  (unexp_trap_o)
  );

  task automatic drive(input vec_t v);
    trap_req      = v.trq;
    trap_is_rnmi  = v.rnmi;
    trap_tgt_priv = v.tgt;
    cur_priv      = v.cur;
    nmi_en        = v.nmie;
    ret_valid     = v.rv;
    ret_kind      = v.rk;
    ret_new_priv  = v.rnew;
  endtask

  task automatic idle_inputs();
    trap_req = 1'b0; trap_is_rnmi = 1'b0; trap_tgt_priv = U; cur_priv = U;
    nmi_en = 1'b1; ret_valid = 1'b0; ret_kind = KX; ret_new_priv = U;
  endtask

  task automatic expect5(input int req, input logic [4:0] exp);
    logic [4:0] act;
    act = {mdt_o, sdt_o, vsdt_o, trap_taken_o, unexp_trap_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d {mdt,sdt,vsdt,taken,unexp} actual=%b expected=%b",
               req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, sample one rising edge later
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect5(1, 5'b10000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      step();
      expect5(int'(VEC[i].req),
              {VEC[i].emdt, VEC[i].esdt, VEC[i].evsdt, VEC[i].etak, VEC[i].eunx});
    end

    // R11 pulses drop after one cycle, bits hold while idle (mdt=1 here)
    idle_inputs();
    step();
    expect5(11, 5'b10000);
    step();
    expect5(11, 5'b10000);

    // R3 back-to-back reentry: two pulses, each a single cycle
    trap_req = 1'b1; trap_tgt_priv = M; cur_priv = S;
    step();
    expect5(3, 5'b10001);
    step();
    expect5(3, 5'b10001);
    idle_inputs();
    step();
    expect5(11, 5'b10000);

    // R10 ignored return must not clear supervisor bits either
    trap_req = 1'b1; trap_tgt_priv = S; cur_priv = U;
    step();
    expect5(6, 5'b11010);
    trap_req = 1'b1; trap_is_rnmi = 1'b1; trap_tgt_priv = M; cur_priv = M;
    ret_valid = 1'b1; ret_kind = KM; ret_new_priv = U;
    step();
    expect5(10, 5'b11010);

    // R1 reset mid-run restores the reset values
    idle_inputs();
    rst = 1'b1;
    step();
    rst = 1'b0;
    expect5(1, 5'b10000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule